// File: doc/BRIEF.md
# Low-Power State Manager for an LPDDR Memory Controller

This block sits beside the command scheduler of an LPDDR memory controller and decides when the memory goes into, and comes back from, four power-saving states: self-refresh, precharge power-down, deep power-down and clock stop. Software supplies one enable bit per state and an idle timeout. The controller reports whether reads or writes are still queued (`req_pending`), pulses `req_new` when a new request arrives and pulses `refresh_due` when the refresh scheduler wants a slot. From these inputs the block drives the memory clock-enable and a clock-run gate. It emits a one-cycle command strobe with a code that tells the sequencer which entry or exit to perform. After deep power-down it raises a re-initialisation request, and it reports its current state at all times.

Precharge power-down is entered only after the controller has stayed idle for a programmed number of 2^`UNIT_LOG2`-cycle units. Self-refresh, deep power-down and clock stop are entered as soon as their enable is set and the controller is idle. When more than one enable is set, the block picks the state by a fixed priority. Deep power-down loses the memory contents, so the enable is the only way out, and leaving it hands control to an external initialisation sequence that reports completion on `init_done`. All control pins are plain levels or single-cycle strobes. There is no handshake, and a strobe on `pm_cmd_valid` must be consumed in the cycle it appears.

Top module: `lpm_power_mgr`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, `pm_state` = 0, `cke` = 1, `clk_run` = 1, `pm_cmd_valid` = 0 and `reinit_req` = 0.
- R2: `pm_state` encodings are 0 running, 1 self-refresh, 2 power-down, 3 deep power-down, 4 clock stop and 5 re-initialising. Every change of state except 5→0 raises `pm_cmd_valid` for exactly the one cycle in which the new state first shows. In that cycle `pm_cmd_code` is 0/1 for self-refresh in/out, 2/3 for power-down in/out, 4/5 for deep power-down in/out and 6/7 for clock stop in/out.
- R3: From state 0, self-refresh is entered on the next clock edge when `sref_en` is 1, `deep_en` is 0 and `req_pending` and `req_new` are both 0. It is not entered while a request is pending.
- R4: Self-refresh is left for state 0 on the next edge when `sref_en` is 0 or `req_new` is 1.
- R5: In self-refresh, `refresh_due` has no effect: the state is held and no command is emitted.
- R6: An idle cycle is one with `req_pending` and `req_new` both 0. The idle count restarts on any request and whenever the state is not 0. With `pdn_en` = 1 and `idle_timeout` = T > 0, power-down is entered on the edge after T·2^`UNIT_LOG2` consecutive idle cycles in state 0, provided `refresh_due` is 0 and no higher-priority entry applies. T = 0 disables automatic power-down.
- R7: Power-down is left for state 0 on the next edge when `refresh_due` is 1, `req_new` is 1 or `pdn_en` is 0.
- R8: Deep power-down is held while `deep_en` stays 1, whatever `req_new` and `refresh_due` do.
- R9: Clearing `deep_en` in deep power-down moves to state 5 with `reinit_req` = 1. `reinit_req` stays 1 and no state is entered until `init_done` is seen, after which the state returns to 0.
- R10: Clock stop is entered from an idle state 0 when `ckoff_en` is 1 and neither deep power-down nor self-refresh applies. It is left when `ckoff_en` is 0. In state 4, `clk_run` = 0.
- R11: In self-refresh with `ckoff_en` = 1, `clk_run` is 0, and the state stays 1.
- R12: `cke` is 0 in states 1, 2 and 3 and 1 in every other state.
- R13: When several entries are possible in the same cycle, the priority is deep power-down, then self-refresh, then clock stop, then power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sref_en | input | 1 | Self-refresh enable |
| pdn_en | input | 1 | Automatic power-down enable |
| deep_en | input | 1 | Deep power-down enable |
| ckoff_en | input | 1 | Clock-stop enable |
| idle_timeout | input | TO_W | Idle timeout in units of 2^UNIT_LOG2 clocks, 0 = off |
| req_pending | input | 1 | Reads or writes queued in the controller |
| req_new | input | 1 | A new request arrived this cycle |
| refresh_due | input | 1 | Refresh scheduler needs a slot |
| init_done | input | 1 | Initialisation sequence finished |
| cke | output | 1 | Memory clock-enable |
| clk_run | output | 1 | Memory clock gate, 0 = stopped |
| pm_cmd_valid | output | 1 | One-cycle entry/exit command strobe |
| pm_cmd_code | output | 3 | Entry/exit command code |
| reinit_req | output | 1 | Request for full re-initialisation |
| pm_state | output | 3 | Current power state |

## Verification
The bench builds the block with `TO_W` = 3 and `UNIT_LOG2` = 4, so the longest timeout is 112 cycles and the idle counter saturates within a few hundred cycles. Timeout expiry, its exact boundary, and the race between expiry and a new request therefore all happen many times in a random run of twenty thousand cycles. The bench also compares every cycle against its own cycle model while enables, requests and refresh strobes toggle, and directed sequences cover the timeout boundary, the priority order and the deep power-down recovery.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SREF   = 3'd1,
    ST_PDN    = 3'd2,
    ST_DEEP   = 3'd3,
    ST_CKOFF  = 3'd4,
    ST_REINIT = 3'd5
  } lpm_state_e;

  typedef enum logic [2:0] {
    CMD_SREF_IN   = 3'd0,
    CMD_SREF_OUT  = 3'd1,
    CMD_PDN_IN    = 3'd2,
    CMD_PDN_OUT   = 3'd3,
    CMD_DEEP_IN   = 3'd4,
    CMD_DEEP_OUT  = 3'd5,
    CMD_CKOFF_IN  = 3'd6,
    CMD_CKOFF_OUT = 3'd7
  } lpm_cmd_e;

  typedef struct packed {
    logic sref;
    logic pdn;
    logic deep;
    logic ckoff;
  } lpm_en_t;

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int TO_W      = 8,
  parameter int UNIT_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [TO_W-1:0] timeout,
  output logic            expired
);
  localparam int CW = TO_W + UNIT_LOG2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // Timeout scaled to controller clocks.
  assign limit = {timeout, {UNIT_LOG2{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (cnt_q != {CW{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (timeout != '0) && (cnt_q >= limit);

endmodule

// File: rtl/lpm_state_ctrl.sv
module lpm_state_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpm_en_t    en,
  input  logic       idle,
  input  logic       new_req,
  input  logic       ref_due,
  input  logic       timer_exp,
  input  logic       init_done,
  output lpm_state_e state,
  output logic       cmd_valid,
  output lpm_cmd_e   cmd_code
);
  lpm_state_e st_q, st_d;
  logic       cv_d, cv_q;
  lpm_cmd_e   cc_d, cc_q;

  always_comb begin
    st_d = st_q;
    cv_d = 1'b0;
    cc_d = cc_q;
    unique case (st_q)
      ST_RUN: begin
        // Priority: deep > self-refresh > clock stop > power-down.
        if (en.deep && idle) begin
          st_d = ST_DEEP;  cv_d = 1'b1; cc_d = CMD_DEEP_IN;
        end else if (en.sref && idle) begin
          st_d = ST_SREF;  cv_d = 1'b1; cc_d = CMD_SREF_IN;
        end else if (en.ckoff && idle) begin
          st_d = ST_CKOFF; cv_d = 1'b1; cc_d = CMD_CKOFF_IN;
        end else if (en.pdn && timer_exp && idle && !ref_due) begin
          st_d = ST_PDN;   cv_d = 1'b1; cc_d = CMD_PDN_IN;
        end
      end
      ST_SREF: begin
        // Refresh is internal to the memory here; ref_due is not looked at.
        if (!en.sref || new_req) begin
          st_d = ST_RUN; cv_d = 1'b1; cc_d = CMD_SREF_OUT;
        end
      end
      ST_PDN: begin
        if (ref_due || new_req || !en.pdn) begin
          st_d = ST_RUN; cv_d = 1'b1; cc_d = CMD_PDN_OUT;
        end
      end
      ST_DEEP: begin
        if (!en.deep) begin
          st_d = ST_REINIT; cv_d = 1'b1; cc_d = CMD_DEEP_OUT;
        end
      end
      ST_CKOFF: begin
        if (!en.ckoff) begin
          st_d = ST_RUN; cv_d = 1'b1; cc_d = CMD_CKOFF_OUT;
        end
      end
      ST_REINIT: begin
        if (init_done) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
      cv_q <= 1'b0;
      cc_q <= CMD_SREF_IN;
    end else begin
      st_q <= st_d;
      cv_q <= cv_d;
      cc_q <= cc_d;
    end
  end

  assign state     = st_q;
  assign cmd_valid = cv_q;
  assign cmd_code  = cc_q;

endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       ckoff_en,
  output logic       cke,
  output logic       clk_run,
  output logic       reinit_req
);
  always_comb begin
    cke        = 1'b1;
    clk_run    = 1'b1;
    reinit_req = 1'b0;
    unique case (state)
      ST_SREF:   begin cke = 1'b0; clk_run = !ckoff_en; end
      ST_PDN:    cke = 1'b0;
      ST_DEEP:   cke = 1'b0;
      ST_CKOFF:  clk_run = 1'b0;
      ST_REINIT: reinit_req = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/lpm_power_mgr.sv
module lpm_power_mgr
  import lpm_pkg::*;
#(
  parameter int TO_W      = 8,
  parameter int UNIT_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sref_en,
  input  logic            pdn_en,
  input  logic            deep_en,
  input  logic            ckoff_en,
  input  logic [TO_W-1:0] idle_timeout,
  input  logic            req_pending,
  input  logic            req_new,
  input  logic            refresh_due,
  input  logic            init_done,
  output logic            cke,
  output logic            clk_run,
  output logic            pm_cmd_valid,
  output logic [2:0]      pm_cmd_code,
  output logic            reinit_req,
  output logic [2:0]      pm_state
);
  lpm_en_t    en;
  lpm_state_e state;
  lpm_cmd_e   code;
  logic       idle;
  logic       timer_exp;
  logic       timer_clr;

  assign en        = '{sref: sref_en, pdn: pdn_en, deep: deep_en, ckoff: ckoff_en};
  assign idle      = !req_pending && !req_new;
  assign timer_clr = !idle || (state != ST_RUN);

  lpm_idle_timer #(.TO_W(TO_W), .UNIT_LOG2(UNIT_LOG2)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clr),
    .timeout (idle_timeout),
    .expired (timer_exp)
  );

  lpm_state_ctrl u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .idle      (idle),
    .new_req   (req_new),
    .ref_due   (refresh_due),
    .timer_exp (timer_exp),
    .init_done (init_done),
    .state     (state),
    .cmd_valid (pm_cmd_valid),
    .cmd_code  (code)
  );

  lpm_pin_ctrl u_pins (
    .state      (state),
    .ckoff_en   (ckoff_en),
    .cke        (cke),
    .clk_run    (clk_run),
    .reinit_req (reinit_req)
  );

  assign pm_state    = state;
  assign pm_cmd_code = code;

endmodule

// File: rtl/lpm_power_mgr_chk.sv
module lpm_power_mgr_chk #(
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sref_en,
  input logic            pdn_en,
  input logic            deep_en,
  input logic            ckoff_en,
  input logic [TO_W-1:0] idle_timeout,
  input logic            req_pending,
  input logic            req_new,
  input logic            refresh_due,
  input logic            cke,
  input logic            clk_run,
  input logic            pm_cmd_valid,
  input logic [2:0]      pm_cmd_code,
  input logic            reinit_req,
  input logic [2:0]      pm_state
);
  assert_cke_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd1 || pm_state == 3'd2 || pm_state == 3'd3) |-> !cke);

  assert_cke_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0 || pm_state == 3'd4 || pm_state == 3'd5) |-> cke);

  assert_deep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3 && deep_en) |=> (pm_state == 3'd3));

  assert_deep_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3 && !deep_en) |=> (pm_state == 3'd5 && reinit_req));

  assert_sref_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0 && sref_en && !deep_en && !req_pending && !req_new)
      |=> (pm_state == 3'd1));

  assert_sref_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd1 && sref_en && !req_new) |=> (pm_state == 3'd1 && !pm_cmd_valid));

  assert_ckoff_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd4) |-> !clk_run);

  assert_cmd_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_cmd_valid |-> (pm_state != $past(pm_state)));

  assert_pdn_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd2 && (refresh_due || req_new || !pdn_en))
      |=> (pm_state == 3'd0 && pm_cmd_valid && pm_cmd_code == 3'd3));
endmodule

bind lpm_power_mgr lpm_power_mgr_chk #(.TO_W(TO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sref_en      (sref_en),
  .pdn_en       (pdn_en),
  .deep_en      (deep_en),
  .ckoff_en     (ckoff_en),
  .idle_timeout (idle_timeout),
  .req_pending  (req_pending),
  .req_new      (req_new),
  .refresh_due  (refresh_due),
  .cke          (cke),
  .clk_run      (clk_run),
  .pm_cmd_valid (pm_cmd_valid),
  .pm_cmd_code  (pm_cmd_code),
  .reinit_req   (reinit_req),
  .pm_state     (pm_state)
);

// File: tb/lpm_power_mgr_tb.sv
`timescale 1ns/1ps
module lpm_power_mgr_tb;
  localparam int TO_W = 3;
  localparam int UL   = 4;
  localparam int CW   = TO_W + UL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sref_en = 0, pdn_en = 0, deep_en = 0, ckoff_en = 0;
  logic [TO_W-1:0] idle_to = '0;
  logic pend = 0, newr = 0, refd = 0, initd = 0;
  logic cke, clk_run, cmd_v, reinit;
  logic [2:0] cmd_c, st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_power_mgr #(.TO_W(TO_W), .UNIT_LOG2(UL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sref_en(sref_en), .pdn_en(pdn_en),
    .deep_en(deep_en), .ckoff_en(ckoff_en), .idle_timeout(idle_to),
    .req_pending(pend), .req_new(newr), .refresh_due(refd), .init_done(initd),
    .cke(cke), .clk_run(clk_run), .pm_cmd_valid(cmd_v), .pm_cmd_code(cmd_c),
    .reinit_req(reinit), .pm_state(st)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycle model built from the requirements.
  logic [2:0]    m_st;
  logic [CW-1:0] m_cnt;
  logic          m_cv;
  logic [2:0]    m_cc;

  always @(posedge clk) begin
    logic [2:0] ns;
    logic       v;
    logic [2:0] c;
    logic       idle;
    logic       expd;
    if (!rst_n) begin
      m_st <= 3'd0; m_cnt <= '0; m_cv <= 1'b0; m_cc <= 3'd0;
    end else begin
      idle = !pend && !newr;
      expd = (idle_to != 0) && (m_cnt >= {idle_to, {UL{1'b0}}});
      ns = m_st; v = 1'b0; c = m_cc;
      case (m_st)
        3'd0: if (deep_en && idle) begin ns = 3; v = 1; c = 4; end
              else if (sref_en && idle) begin ns = 1; v = 1; c = 0; end
              else if (ckoff_en && idle) begin ns = 4; v = 1; c = 6; end
              else if (pdn_en && expd && idle && !refd) begin ns = 2; v = 1; c = 2; end
        3'd1: if (!sref_en || newr) begin ns = 0; v = 1; c = 1; end
        3'd2: if (refd || newr || !pdn_en) begin ns = 0; v = 1; c = 3; end
        3'd3: if (!deep_en) begin ns = 5; v = 1; c = 5; end
        3'd4: if (!ckoff_en) begin ns = 0; v = 1; c = 7; end
        default: if (initd) ns = 0;
      endcase
      if (!idle || m_st != 3'd0) m_cnt <= '0;
      else if (m_cnt != {CW{1'b1}}) m_cnt <= m_cnt + 1'b1;
      m_st <= ns; m_cv <= v; m_cc <= c;
    end
  end

  function automatic logic exp_cke(logic [2:0] s);
    return !(s == 3'd1 || s == 3'd2 || s == 3'd3);
  endfunction

  function automatic logic exp_run(logic [2:0] s, logic ck);
    return !(s == 3'd4 || (s == 3'd1 && ck));
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2 model state", st, m_st);
      check("R2 model strobe", cmd_v, m_cv);
      if (m_cv) check("R2 model code", cmd_c, m_cc);
      check("R12 model cke", cke, exp_cke(m_st));
      check("R10 model clk_run", clk_run, exp_run(m_st, ckoff_en));
      check("R9 model reinit", reinit, m_st == 3'd5);
    end
  end

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pdn_en = 1; idle_to = 3'd1;
    step(3);
    check("R1 state", st, 0);
    check("R1 cke", cke, 1);
    check("R1 clk_run", clk_run, 1);
    check("R1 strobe", cmd_v, 0);
    check("R1 reinit", reinit, 0);
    rst_n = 1;
    step(1);
    check("R1 first cycle state", st, 0);
    // Timeout boundary: 16 idle cycles then entry on the 17th edge.
    step(15);
    check("R6 before timeout", st, 0);
    step(1);
    check("R6 at timeout", st, 2);
    check("R2 pdn enter strobe", cmd_v, 1);
    check("R2 pdn enter code", cmd_c, 2);
    check("R12 cke in pdn", cke, 0);
    refd = 1; step(1); refd = 0; pdn_en = 0;
    check("R7 refresh exit", st, 0);
    check("R7 exit code", cmd_c, 3);
    // Self-refresh.
    pend = 1; sref_en = 1; step(2);
    check("R3 pending blocks", st, 0);
    pend = 0; step(1);
    check("R3 entry", st, 1);
    check("R2 sref code", cmd_c, 0);
    ckoff_en = 1; step(1);
    check("R11 state", st, 1);
    check("R11 clk_run", clk_run, 0);
    refd = 1; step(3);
    check("R5 held", st, 1);
    check("R5 no strobe", cmd_v, 0);
    refd = 0; ckoff_en = 0; newr = 1; step(1); newr = 0;
    check("R4 new request exit", st, 0);
    check("R4 exit code", cmd_c, 1);
    step(1);
    check("R3 reentry", st, 1);
    sref_en = 0; step(1);
    check("R4 enable exit", st, 0);
    // Priority and deep power-down.
    sref_en = 1; pdn_en = 1; ckoff_en = 1; deep_en = 1; step(1);
    check("R13 deep wins", st, 3);
    check("R8 deep code", cmd_c, 4);
    newr = 1; refd = 1; step(3); newr = 0; refd = 0;
    check("R8 held", st, 3);
    deep_en = 0; step(1);
    check("R9 reinit state", st, 5);
    check("R9 reinit req", reinit, 1);
    check("R9 exit code", cmd_c, 5);
    step(3);
    check("R9 waits", st, 5);
    initd = 1; step(1); initd = 0;
    check("R9 done", st, 0);
    check("R9 req drop", reinit, 0);
    step(1);
    check("R13 sref over ckoff", st, 1);
    sref_en = 0; step(1);
    check("R4 exit", st, 0);
    step(1);
    check("R13 ckoff over pdn", st, 4);
    check("R10 code", cmd_c, 6);
    check("R10 clk_run", clk_run, 0);
    check("R12 cke in ckoff", cke, 1);
    ckoff_en = 0; step(1);
    check("R10 exit", st, 0);
    check("R10 exit code", cmd_c, 7);
    check("R10 clk_run back", clk_run, 1);
    idle_to = 0; step(100);
    check("R6 zero timeout", st, 0);
    pdn_en = 0;
    // Random phase, compared every cycle against the model.
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(59) == 0) sref_en  = ~sref_en;
      if ($urandom_range(39) == 0) pdn_en   = ~pdn_en;
      if ($urandom_range(149) == 0) deep_en = ~deep_en;
      if ($urandom_range(69) == 0) ckoff_en = ~ckoff_en;
      if ($urandom_range(19) == 0) pend     = ~pend;
      newr  = ($urandom_range(49) == 0);
      refd  = ($urandom_range(59) == 0);
      initd = ($urandom_range(5) == 0);
      if ($urandom_range(299) == 0) idle_to = TO_W'($urandom_range(7));
      step(1);
    end
    summary();
  end
endmodule